// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Controller

This block sits beside a processor core and turns interrupt requests into the 20-bit address of a service routine. It takes three kinds of request. The first is a level-sensitive maskable request, which is gated by an enable bit. The second is a nonmaskable input that acts on its rising edge. The third is a software request that carries its own type number. For a maskable request, the controller runs a handshake with the interrupting device. It drives its active-low acknowledge output low in two separate pulses and takes the 8-bit type number from the device's data byte during the second pulse.

Once the type is known, the controller reads four bytes from the vector table at the bottom of memory. The table entry for type `t` starts at byte address `4*t`. The controller then forms `segment*16 + offset` and reports it together with the type through a one-cycle `done` strobe. Saving the return state is left to the core.

The state machine has seven states. `ST_IDLE` arbitrates. `ST_ACK1`, `ST_GAP` and `ST_ACK2` form the two-pulse handshake. `ST_READ` and `ST_TAKE` alternate once per table byte. `ST_DONE` raises the strobe. The transitions are:
- `ST_IDLE` goes to `ST_READ` on a nonmaskable or software request, and to `ST_ACK1` on an enabled maskable request.
- `ST_ACK1` goes to `ST_GAP` after ACK_LO cycles.
- `ST_GAP` goes to `ST_ACK2` after ACK_HI cycles.
- `ST_ACK2` goes to `ST_READ` after ACK_LO cycles and captures the type.
- `ST_READ` always goes to `ST_TAKE`.
- `ST_TAKE` goes back to `ST_READ` for the next byte, or to `ST_DONE` after the fourth byte.
- `ST_DONE` goes to `ST_IDLE`.

Top module: `ivac_ctrl`

## Requirements
- R1: After reset, the outputs are `ack_n`=1, `mem_rd`=0 and `done`=0, with `svc_type`=0 and `target`=0.
- R2: An enabled maskable request produces exactly two low pulses on `ack_n`. Each pulse lasts ACK_LO cycles, and the pulses are separated by ACK_HI high cycles. The type is `ack_data` as it stands in the last cycle of the second pulse. Data shown during the first pulse is not used.
- R3: When `int_enable`=0, a high `intr_req` causes no acknowledge pulse, no memory read and no `done`.
- R4: For type `t`, the controller reads four single bytes at addresses `4*t+0`, `4*t+1`, `4*t+2` and `4*t+3`, in that order. Each `mem_rd` is a single cycle, and a read is issued at most every second cycle. `mem_rdata` is taken one cycle after `mem_rd`. Every table address lies below 0x400.
- R5: Bytes +0 and +1 are the offset, low byte first. Bytes +2 and +3 are the segment, low byte first. `target` = (segment<<4) + offset modulo 2^20. For example, segment 0xFFFF with offset 0x0020 gives 0x00010.
- R6: A rising edge on `nmi_in` is serviced as type 2 whatever the value of `int_enable`. It produces no acknowledge pulse and reads addresses 0x08 to 0x0B.
- R7: An `nmi_in` held high is serviced once only.
- R8: If a nonmaskable edge and an enabled maskable request arrive in the same cycle, type 2 is serviced first. A maskable request still held afterwards is serviced next.
- R9: A one-cycle `sw_req` while idle is serviced with type `sw_type` and no acknowledge pulse. It ranks below the nonmaskable input and above the maskable request.
- R10: A `sw_req` pulse that arrives while a sequence is in progress is dropped.
- R11: `done` is high for exactly one cycle per serviced request, with `target` and `svc_type` valid in that cycle.
- R12: A nonmaskable edge that arrives while a sequence is in progress is held and serviced after that sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| intr_req | input | 1 | Maskable interrupt request, level sensitive |
| nmi_in | input | 1 | Nonmaskable interrupt, rising-edge sensitive |
| int_enable | input | 1 | Enable bit for the maskable request |
| sw_req | input | 1 | One-cycle software interrupt request |
| sw_type | input | 8 | Type number for the software request |
| ack_n | output | 1 | Active-low acknowledge pulses |
| ack_data | input | 8 | Low data byte driven by the interrupting device |
| mem_rd | output | 1 | Table byte read strobe |
| mem_addr | output | 20 | Table byte address |
| mem_rdata | input | 8 | Read byte, valid one cycle after `mem_rd` |
| done | output | 1 | One-cycle completion strobe |
| svc_type | output | 8 | Type number being serviced |
| target | output | 20 | Service-routine address |

## Verification
Inputs are applied just after a falling edge, and the latency is counted in falling edges up to the one at which `done` is first seen high. Software and nonmaskable requests are due at 9, which covers one arbitration edge and four two-cycle byte reads. A maskable request is due at 1 + 2*ACK_LO + ACK_HI + 8, which is 15 with the default parameters. Each check compares the measured latency with that figure. It reads the acknowledge and memory activity from a falling-edge monitor, and reads `target` and `svc_type` from the same negedge sample in which `done` is high.

// File: rtl/ivac_pkg.sv
package ivac_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK1,
        ST_GAP,
        ST_ACK2,
        ST_READ,
        ST_TAKE,
        ST_DONE
    } ivac_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_SW,
        SRC_MASK
    } ivac_src_e;

    localparam logic [7:0] NMI_TYPE = 8'd2;
endpackage

// File: rtl/ivac_req_arb.sv
module ivac_req_arb
    import ivac_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idle,
    input  logic      nmi_in,
    input  logic      intr_req,
    input  logic      int_enable,
    input  logic      sw_req,
    output ivac_src_e src
);
    logic nmi_q;
    logic nmi_pend;
    logic nmi_rise;
    logic nmi_any;
    logic nmi_take;

    assign nmi_rise = nmi_in & ~nmi_q;
    assign nmi_any  = nmi_pend | nmi_rise;
    assign nmi_take = idle & nmi_any;

    // Priority: nonmaskable, then software, then maskable.
    always_comb begin
        if (nmi_any)
            src = SRC_NMI;
        else if (sw_req)
            src = SRC_SW;
        else if (intr_req && int_enable)
            src = SRC_MASK;
        else
            src = SRC_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q    <= nmi_in;
            nmi_pend <= nmi_any & ~nmi_take;
        end
    end
endmodule

// File: rtl/ivac_vec_asm.sv
module ivac_vec_asm #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = WORD_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [1:0]        idx,
    input  logic [7:0]        rdata,
    output logic [ADDR_W-1:0] target
);
    localparam int NBYTES = 2 * WORD_W / 8;
    localparam int WB     = WORD_W / 8;
    localparam int SHIFT  = ADDR_W - WORD_W;

    logic [8*NBYTES-1:0] bytes_q;
    logic [WORD_W-1:0]   offset_w;
    logic [WORD_W-1:0]   segment_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes_q <= '0;
        end else if (clr) begin
            bytes_q <= '0;
        end else if (load) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (idx == 2'(b))
                    bytes_q[8*b +: 8] <= rdata;
            end
        end
    end

    // Lower word is the offset, upper word is the segment, both little-endian.
    assign offset_w  = bytes_q[0 +: WORD_W];
    assign segment_w = bytes_q[8*WB +: WORD_W];
    assign target    = {segment_w, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, offset_w};
endmodule

// File: rtl/ivac_ctrl.sv
module ivac_ctrl
    import ivac_pkg::*;
#(
    parameter int ACK_LO = 2,
    parameter int ACK_HI = 2,
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                intr_req,
    input  logic                nmi_in,
    input  logic                int_enable,
    input  logic                sw_req,
    input  logic [7:0]          sw_type,
    output logic                ack_n,
    input  logic [7:0]          ack_data,
    output logic                mem_rd,
    output logic [WORD_W+3:0]   mem_addr,
    input  logic [7:0]          mem_rdata,
    output logic                done,
    output logic [7:0]          svc_type,
    output logic [WORD_W+3:0]   target
);
    localparam int ADDR_W = WORD_W + 4;
    localparam int CMAX   = (ACK_LO > ACK_HI) ? ACK_LO : ACK_HI;
    localparam int CNT_W  = $clog2(CMAX) + 1;
    localparam int PAD_W  = ADDR_W - 10;

    ivac_state_e state, state_nxt;
    ivac_src_e   src;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       bidx;
    logic [7:0]       type_r;
    logic [7:0]       type_nxt;
    logic             start;

    ivac_req_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (state == ST_IDLE),
        .nmi_in     (nmi_in),
        .intr_req   (intr_req),
        .int_enable (int_enable),
        .sw_req     (sw_req),
        .src        (src)
    );

    ivac_vec_asm #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .load   (state == ST_TAKE),
        .idx    (bidx),
        .rdata  (mem_rdata),
        .target (target)
    );

    // Next-state and type selection
    always_comb begin
        state_nxt = state;
        type_nxt  = type_r;
        start     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                unique case (src)
                    SRC_NMI: begin
                        state_nxt = ST_READ;
                        type_nxt  = NMI_TYPE;
                        start     = 1'b1;
                    end
                    SRC_SW: begin
                        state_nxt = ST_READ;
                        type_nxt  = sw_type;
                        start     = 1'b1;
                    end
                    SRC_MASK: begin
                        state_nxt = ST_ACK1;
                        start     = 1'b1;
                    end
                    default: state_nxt = ST_IDLE;
                endcase
            end
            ST_ACK1: if (cnt == CNT_W'(ACK_LO - 1)) state_nxt = ST_GAP;
            ST_GAP:  if (cnt == CNT_W'(ACK_HI - 1)) state_nxt = ST_ACK2;
            ST_ACK2: begin
                if (cnt == CNT_W'(ACK_LO - 1)) begin
                    state_nxt = ST_READ;
                    type_nxt  = ack_data;
                end
            end
            ST_READ: state_nxt = ST_TAKE;
            ST_TAKE: state_nxt = (bidx == 2'd3) ? ST_DONE : ST_READ;
            ST_DONE: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            bidx   <= '0;
            type_r <= '0;
        end else begin
            state  <= state_nxt;
            type_r <= type_nxt;
            cnt    <= (state_nxt != state) ? '0 : cnt + 1'b1;
            if (start)
                bidx <= '0;
            else if (state == ST_TAKE)
                bidx <= bidx + 2'd1;
        end
    end

    // Moore outputs
    always_comb begin
        ack_n    = !((state == ST_ACK1) || (state == ST_ACK2));
        mem_rd   = (state == ST_READ);
        mem_addr = {{PAD_W{1'b0}}, type_r, bidx};
        done     = (state == ST_DONE);
        svc_type = type_r;
    end
endmodule

// File: rtl/ivac_ctrl_chk.sv
module ivac_ctrl_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_n,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done
);
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_table_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr[ADDR_W-1:10] == '0));

    p_read_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    p_ack_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> !mem_rd);

    p_done_after_last_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_rd, 2) && ($past(mem_addr[1:0], 2) == 2'b11)));

    p_no_ack_at_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ack_n);
endmodule

bind ivac_ctrl ivac_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_n    (ack_n),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .done     (done)
);

// File: tb/ivac_ctrl_bench.sv
`timescale 1ns/1ps
module ivac_ctrl_bench;
    localparam int LO = 2;
    localparam int HI = 2;
    localparam int LAT_FAST = 9;
    localparam int LAT_MASK = 1 + 2*LO + HI + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic intr_req = 1'b0, nmi_in = 1'b0, int_enable = 1'b0, sw_req = 1'b0;
    logic [7:0] sw_type = '0, ack_data = '0, mem_rdata = '0;
    logic ack_n, mem_rd, done;
    logic [19:0] mem_addr, target;
    logic [7:0] svc_type;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mem [0:1023];

    // Monitor state
    int pulses, lo_cyc, rd_cnt, done_cnt;
    logic prev_ack = 1'b1;
    logic [19:0] rd_addr [4];
    logic [7:0]  done_type [4];
    logic [19:0] done_tgt [4];
    logic [7:0]  dev_type = '0;
    logic        drop_irq = 1'b0;

    always #2.5 clk = ~clk;

    ivac_ctrl #(.ACK_LO(LO), .ACK_HI(HI)) u_ivac_ctrl (
        .clk(clk), .rst_n(rst_n), .intr_req(intr_req), .nmi_in(nmi_in),
        .int_enable(int_enable), .sw_req(sw_req), .sw_type(sw_type),
        .ack_n(ack_n), .ack_data(ack_data), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .done(done), .svc_type(svc_type), .target(target)
    );

    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];

    always @(negedge clk) begin
        if (!ack_n && prev_ack) pulses = pulses + 1;
        if (!ack_n) lo_cyc = lo_cyc + 1;
        prev_ack = ack_n;
        if (mem_rd) begin
            if (rd_cnt < 4) rd_addr[rd_cnt] = mem_addr;
            rd_cnt = rd_cnt + 1;
        end
        if (done) begin
            if (done_cnt < 4) begin
                done_type[done_cnt] = svc_type;
                done_tgt[done_cnt]  = target;
            end
            done_cnt = done_cnt + 1;
        end
        ack_data = (pulses >= 2) ? dev_type : 8'hEE;
        if (drop_irq && pulses >= 1) intr_req = 1'b0;
    end

    task automatic mon_clear();
        pulses = 0; lo_cyc = 0; rd_cnt = 0; done_cnt = 0;
        pulses = 0; drop_irq = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_tgt(input logic [7:0] t);
        int b = int'(t) * 4;
        logic [15:0] off = {mem[b+1], mem[b]};
        logic [15:0] seg = {mem[b+3], mem[b+2]};
        return {seg, 4'h0} + {4'h0, off};
    endfunction

    task automatic wait_done(input int start, output int lat);
        lat = start;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            lat++;
            if (done) return;
        end
        lat = -1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ack_n", 32'(ack_n), 1);
        chk("R1 mem_rd", 32'(mem_rd), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 svc_type", 32'(svc_type), 0);
        chk("R1 target", 32'(target), 0);
    endtask

    task automatic t_mask_req(input logic [7:0] t);
        int lat;
        mon_clear();
        dev_type = t; drop_irq = 1'b1;
        int_enable = 1'b1; intr_req = 1'b1;
        wait_done(0, lat);
        chk("R2 latency", 32'(lat), 32'(LAT_MASK));
        chk("R2 pulses", 32'(pulses), 2);
        chk("R2 low cycles", 32'(lo_cyc), 32'(2*LO));
        chk("R2 type from second pulse", 32'(svc_type), 32'(t));
        for (int i = 0; i < 4; i++)
            chk("R4 byte address", 32'(rd_addr[i]), 32'(int'(t)*4 + i));
        chk("R5 target", 32'(target), 32'(exp_tgt(t)));
        idle(6);
        chk("R11 done cycles", 32'(done_cnt), 1);
        chk("R4 read count", 32'(rd_cnt), 4);
    endtask

    task automatic t_masked();
        mon_clear();
        int_enable = 1'b0; intr_req = 1'b1;
        idle(40);
        chk("R3 pulses", 32'(pulses), 0);
        chk("R3 reads", 32'(rd_cnt), 0);
        chk("R3 done", 32'(done_cnt), 0);
        intr_req = 1'b0;
    endtask

    task automatic t_nmi_hold();
        int lat;
        mon_clear();
        int_enable = 1'b0; nmi_in = 1'b1;
        wait_done(0, lat);
        chk("R6 latency", 32'(lat), LAT_FAST);
        chk("R6 type", 32'(svc_type), 2);
        chk("R6 target", 32'(target), 32'(exp_tgt(8'd2)));
        chk("R6 first read", 32'(rd_addr[0]), 32'h08);
        chk("R6 last read", 32'(rd_addr[3]), 32'h0B);
        idle(30);
        chk("R6 pulses", 32'(pulses), 0);
        chk("R7 single service", 32'(done_cnt), 1);
        nmi_in = 1'b0;
        idle(2);
    endtask

    task automatic t_prio(input logic [7:0] t);
        mon_clear();
        dev_type = t; drop_irq = 1'b1;
        int_enable = 1'b1; intr_req = 1'b1; nmi_in = 1'b1;
        idle(40);
        chk("R8 count", 32'(done_cnt), 2);
        chk("R8 first type", 32'(done_type[0]), 2);
        chk("R8 second type", 32'(done_type[1]), 32'(t));
        chk("R8 second target", 32'(done_tgt[1]), 32'(exp_tgt(t)));
        nmi_in = 1'b0;
        idle(2);
    endtask

    task automatic t_sw(input logic [7:0] t);
        int lat;
        mon_clear();
        sw_type = t; sw_req = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
        wait_done(1, lat);
        chk("R9 latency", 32'(lat), LAT_FAST);
        chk("R9 type", 32'(svc_type), 32'(t));
        chk("R9 target", 32'(target), 32'(exp_tgt(t)));
        chk("R9 pulses", 32'(pulses), 0);
        idle(4);
    endtask

    task automatic t_sw_prio();
        mon_clear();
        int_enable = 1'b1; intr_req = 1'b1; drop_irq = 1'b0; dev_type = 8'h31;
        sw_type = 8'h12; sw_req = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
        intr_req = 1'b0;
        idle(30);
        chk("R9 priority over maskable", 32'(done_type[0]), 32'h12);
        chk("R9 no ack", 32'(pulses), 0);
    endtask

    task automatic t_sw_busy();
        mon_clear();
        dev_type = 8'h55; drop_irq = 1'b1;
        int_enable = 1'b1; intr_req = 1'b1;
        idle(3);
        sw_type = 8'h66; sw_req = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
        idle(50);
        chk("R10 dropped count", 32'(done_cnt), 1);
        chk("R10 type kept", 32'(done_type[0]), 32'h55);
    endtask

    task automatic t_nmi_busy();
        mon_clear();
        sw_type = 8'h40; sw_req = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
        idle(2);
        nmi_in = 1'b1;
        idle(40);
        chk("R12 count", 32'(done_cnt), 2);
        chk("R12 first type", 32'(done_type[0]), 32'h40);
        chk("R12 second type", 32'(done_type[1]), 2);
        nmi_in = 1'b0;
        idle(2);
    endtask

    task automatic t_wrap();
        t_sw(8'hFF);
        chk("R5 wrap target", 32'(done_tgt[0]), 32'h00010);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 37 + 11) & 255);
        mem[1020] = 8'h20; mem[1021] = 8'h00; mem[1022] = 8'hFF; mem[1023] = 8'hFF;
        mon_clear();
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_mask_req(8'h03);
        t_mask_req(8'hA7);
        t_masked();
        t_nmi_hold();
        t_prio(8'h21);
        t_sw(8'h77);
        t_sw_prio();
        t_sw_busy();
        t_nmi_busy();
        t_wrap();
        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule